// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a down-counting timer that raises an interrupt request when its count runs out. Software sets it up through four word registers on a simple write port: a timer entry (vector number, mask and mode), an initial count, and a divide setting that picks how many clock cycles make one count tick. A fourth register reads the live count back. A read port with its own select returns any of the four registers combinationally.

In one-shot mode the count runs from the initial value down to zero, stays there, and requests one interrupt. In periodic mode the count reloads after reaching zero and requests an interrupt on every reload, so the period is the initial count plus one ticks. A masked timer keeps counting but requests nothing. The request is a one-cycle pulse carrying the 8-bit vector from the entry; whatever consumes and prioritises that request sits outside this block.

Top module: `local_irq_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0), the initial count, divide setting and current count read 0, and no pulse is raised.
- R2: A write to the divide register (select 2) keeps only data bits 3, 1 and 0; the readback shows the other bits as 0.
- R3: The tick period is 2^S cycles, where S = (C + 1) mod 8 and C is the 3-bit value {bit 3, bit 1, bit 0} of the divide register; C = 7 gives one tick per cycle and C = 0 one tick per two cycles.
- R4: In one-shot mode (entry bit 17 = 0) with initial count N > 0, the pulse appears (N+1)·2^S cycles after the edge that wrote the initial count, appears only once, and the count then stays at 0; with N = 0 no pulse appears.
- R5: In periodic mode (entry bit 17 = 1) with N > 0, the first pulse appears (N+1)·2^S cycles after the initial-count write and further pulses follow every (N+1)·2^S cycles.
- R6: In periodic mode an initial count of 0 produces no pulse at all.
- R7: While entry bit 16 is set no pulse appears, yet the count keeps running; clearing the bit lets pulses resume.
- R8: A write to the initial count (select 1) restarts both the count and the tick divider from that edge.
- R9: The pulse lasts one cycle and the vector output carries entry bits 7:0 along with it.
- R10: The current count (select 3) reads N minus the ticks elapsed since the initial-count write; writes to select 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one register written per cycle |
| wr_sel | input | 2 | Write select: 0 entry, 1 initial count, 2 divide, 3 current count (ignored) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational readback of the selected register |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector delivered with the request |

## Verification
The assertions assume that reset is held for at least one edge before any write, and that each write strobe lasts a single cycle with a stable select. They also assume the mode bit does not flip while a one-shot count sits at zero with a pending expiry; the stimulus only changes the entry before an initial-count write or, for the mask test, while the mode stays periodic. Every write is issued from a task that raises the strobe for exactly one edge and then leaves the bus idle, so back-to-back writes are always separated by a quiet cycle.

// File: rtl/lirq_pkg.sv
// Shared constants for the local interrupt timer.
// Assumes a 32-bit register word and an 8-bit vector.
package lirq_pkg;

    // register selects shared by the read and the write port
    localparam logic [1:0] SEL_ENTRY = 2'd0;
    localparam logic [1:0] SEL_INIT  = 2'd1;
    localparam logic [1:0] SEL_DIV   = 2'd2;
    localparam logic [1:0] SEL_CURR  = 2'd3;

    // entry fields
    localparam int ENT_MASK_BIT     = 16;
    localparam int ENT_PERIODIC_BIT = 17;

    // divide register: only these bits are stored
    localparam logic [3:0] DIV_KEEP = 4'b1011;

    // width of the prescale shift; the divider spans 2^SHIFT_W - 1 bits
    localparam int SHIFT_W = 3;

    typedef enum logic {
        MODE_ONESHOT  = 1'b0,
        MODE_PERIODIC = 1'b1
    } lirq_mode_e;

    // fold the stored divide bits into the prescale shift
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] div);
        logic [SHIFT_W-1:0] code;
        code = {div[3], div[1:0]};
        return code + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/lirq_cfg_regs.sv
// Register file of the timer: entry, initial count and divide setting.
// Assumes one write per cycle; select 3 is read-only and writes to it drop.
// Produces a load strobe on every initial-count write.
module lirq_cfg_regs
    import lirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] entry_q,
    output logic [DATA_W-1:0] init_q,
    output logic [3:0]        div_q,
    output logic              load
);

    localparam logic [DATA_W-1:0] ENTRY_RST = DATA_W'(1) << ENT_MASK_BIT;

    // initial-count write restarts the counter and divider
    assign load = wr_en && (wr_sel == SEL_INIT);

    // register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= ENTRY_RST;
            init_q  <= '0;
            div_q   <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ENTRY: entry_q <= wr_data;
                SEL_INIT:  init_q  <= wr_data;
                SEL_DIV:   div_q   <= wr_data[3:0] & DIV_KEEP;
                default:   ;
            endcase
        end
    end

    // R2
    div_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q & ~DIV_KEEP) == 4'b0000);

endmodule

// File: rtl/lirq_prescaler.sv
// Free-running divider producing one tick every 2^shift cycles.
// Assumes shift is below 2^SHIFT_W; clear restarts the divider so the first
// tick arrives a full period after it.
module lirq_prescaler
    import lirq_pkg::*;
#(
    parameter int SW = SHIFT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [SW-1:0] shift,
    output logic          tick
);

    localparam int PRE_W = (1 << SW) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] span;

    // bit g of the span is part of the divide window when g < shift
    for (genvar g = 0; g < PRE_W; g++) begin : g_span
        assign span[g] = (32'(shift) > g);
    end

    // tick when every bit inside the window is one
    assign tick = &(pre_q | ~span);

    // divider count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R8
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear && shift != '0 |=> !tick);

endmodule

// File: rtl/lirq_downcounter.sv
// Down counter with one-shot and periodic expiry and the request pulse.
// Assumes tick lasts one cycle; load has priority over tick.
// One-shot arms only for a nonzero load value; periodic reload of zero stops.
module lirq_downcounter
    import lirq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  lirq_mode_e       mode,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    logic armed_q;
    logic at_zero;
    logic expire;

    assign at_zero = (cur_cnt == '0);

    // a tick that finds zero ends the period when a period is live
    always_comb begin
        expire = 1'b0;
        if (tick && at_zero && !load) begin
            if (mode == MODE_PERIODIC) expire = (reload_val != '0);
            else                       expire = armed_q;
        end
    end

    // count, arm flag and request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cnt    <= '0;
            armed_q    <= 1'b0;
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= expire && !masked;
            if (expire && !masked) irq_vector <= vector;
            if (load) begin
                cur_cnt <= load_val;
                armed_q <= (load_val != '0);
            end else if (tick) begin
                if (!at_zero) begin
                    cur_cnt <= cur_cnt - CNT_W'(1);
                end else if (expire) begin
                    if (mode == MODE_PERIODIC) cur_cnt <= reload_val;
                    else                       armed_q <= 1'b0;
                end
            end
        end
    end

    // R9
    single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !tick |=> $stable(cur_cnt));

    // R4
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_ONESHOT && at_zero && !load |=> cur_cnt == '0);

endmodule

// File: rtl/local_irq_timer.sv
// Top of the local interrupt timer: registers, prescaler and down counter.
// Assumes a single-cycle write strobe; readback is combinational.
module local_irq_timer
    import lirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [DATA_W-1:0]  entry_q;
    logic [DATA_W-1:0]  init_q;
    logic [3:0]         div_q;
    logic               load;
    logic               tick;
    logic [DATA_W-1:0]  cur_cnt;
    logic [SHIFT_W-1:0] shift;
    lirq_mode_e         mode;

    lirq_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .entry_q (entry_q),
        .init_q  (init_q),
        .div_q   (div_q),
        .load    (load)
    );

    assign shift = div_to_shift(div_q);
    assign mode  = lirq_mode_e'(entry_q[ENT_PERIODIC_BIT]);

    lirq_prescaler #(.SW(SHIFT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .shift (shift),
        .tick  (tick)
    );

    lirq_downcounter #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (wr_data),
        .reload_val (init_q),
        .tick       (tick),
        .mode       (mode),
        .masked     (entry_q[ENT_MASK_BIT]),
        .vector     (entry_q[VEC_W-1:0]),
        .cur_cnt    (cur_cnt),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

    // readback mux
    always_comb begin
        case (rd_sel)
            SEL_ENTRY: rd_data = entry_q;
            SEL_INIT:  rd_data = init_q;
            SEL_DIV:   rd_data = {{(DATA_W-4){1'b0}}, div_q};
            default:   rd_data = cur_cnt;
        endcase
    end

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_q[ENT_MASK_BIT] |=> !irq_pulse);

    // R6
    nonzero_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(init_q) != '0);

endmodule

// File: tb/tb_local_irq_timer.sv
module tb_local_irq_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    local_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    typedef struct packed {
        logic [3:0]  div;
        logic        per;
        logic [7:0]  n;
        logic [7:0]  vec;
        int          first;   // cycles to first pulse, 0 = none
        int          period;  // cycles between pulses, 0 = one-shot
    } row_t;

    // expected latencies: (N+1) * 2^((code+1) mod 8), code = {b3,b1,b0} (R3)
    localparam row_t TABLE [6] = '{
        '{4'hB, 1'b0, 8'd3, 8'h41,   4, 0},
        '{4'h0, 1'b1, 8'd2, 8'h52,   6, 6},
        '{4'h1, 1'b1, 8'd1, 8'h63,   8, 8},
        '{4'h8, 1'b0, 8'd2, 8'h74,  96, 0},
        '{4'hA, 1'b0, 8'd1, 8'h85, 256, 0},
        '{4'h3, 1'b1, 8'd0, 8'h96,   0, 0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        rd_sel = s;
        #1;
        d = rd_data;
    endtask

    // counts edges until a pulse is seen; k = -1 when none within limit
    task automatic wait_pulse(input int limit, output int k, output logic [7:0] v);
        k = 0; v = 8'h00;
        while (k < limit) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (irq_pulse) begin
                v = irq_vector;
                return;
            end
        end
        k = -1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c1;
        logic [7:0]  v;
        int          k;
        string       tag;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); check("R1 entry", d, 32'h0001_0000);
        rd(2'd1, d); check("R1 init", d, 32'd0);
        rd(2'd2, d); check("R1 div", d, 32'd0);
        rd(2'd3, d); check("R1 count", d, 32'd0);
        check("R1 pulse", {31'd0, irq_pulse}, 32'd0);

        // R2 divide bit keeping
        wr(2'd2, 32'hFFFF_FFF4); rd(2'd2, d); check("R2 div 0xF4", d, 32'h0);
        wr(2'd2, 32'h0000_00FF); rd(2'd2, d); check("R2 div 0xFF", d, 32'hB);

        // table walk: R3, R4, R5, R6, R9
        foreach (TABLE[i]) begin
            tag = TABLE[i].per ? (TABLE[i].n == 0 ? "R6" : "R5") : "R4";
            wr(2'd2, {28'd0, TABLE[i].div});
            wr(2'd0, {14'd0, TABLE[i].per, 1'b0, 8'd0, TABLE[i].vec});
            wr(2'd1, {24'd0, TABLE[i].n});
            if (TABLE[i].first == 0) begin
                wait_pulse(600, k, v);
                check({tag, " no pulse"}, k, -1);
            end else begin
                wait_pulse(TABLE[i].first + 5, k, v);
                check({tag, " R3 first latency"}, k, TABLE[i].first);
                check("R9 vector", {24'd0, v}, {24'd0, TABLE[i].vec});
                if (TABLE[i].period != 0) begin
                    wait_pulse(TABLE[i].period + 5, k, v);
                    check("R5 period", k, TABLE[i].period);
                end else begin
                    wait_pulse(TABLE[i].first * 2 + 10, k, v);
                    check("R4 single fire", k, -1);
                    rd(2'd3, d); check("R4 count held at zero", d, 32'd0);
                end
            end
        end

        // R4 one-shot with zero count never fires
        wr(2'd2, 32'hB);
        wr(2'd0, 32'h0000_0011);
        wr(2'd1, 32'd0);
        wait_pulse(20, k, v);
        check("R4 zero count one-shot", k, -1);

        // R10 readback and ignored write to select 3
        wr(2'd1, 32'd10);
        rd(2'd3, d); check("R10 count at load", d, 32'd10);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd(2'd3, d); check("R10 count after 4 ticks", d, 32'd6);
        wr(2'd3, 32'h55);
        rd(2'd3, d); check("R10 write to count ignored", d, 32'd4);
        rd(2'd1, d); check("R10 init unchanged", d, 32'd10);

        // R7 masked periodic keeps counting, no pulse
        wr(2'd0, 32'h0003_0099);
        wr(2'd1, 32'd2);
        wait_pulse(20, k, v);
        check("R7 masked no pulse", k, -1);
        rd(2'd3, c1);
        @(posedge clk); @(negedge clk);
        rd(2'd3, d);
        check("R7 count runs while masked", d, (c1 == 0) ? 32'd2 : c1 - 1);
        wr(2'd0, 32'h0002_0099);
        wait_pulse(10, k, v);
        check("R7 pulse after unmask", {31'd0, k != -1}, 32'd1);
        check("R9 vector after unmask", {24'd0, v}, 32'h99);
        wait_pulse(10, k, v);
        check("R7 period after unmask", k, 3);

        // R8 restart of count
        wr(2'd0, 32'h0000_0021);
        wr(2'd1, 32'd5);
        repeat (3) @(posedge clk);
        wr(2'd1, 32'd5);
        wait_pulse(20, k, v);
        check("R8 count restart", k, 6);

        // R8 restart of divider (tick period 4)
        wr(2'd2, 32'h1);
        wr(2'd1, 32'd1);
        repeat (2) @(posedge clk);
        wr(2'd1, 32'd1);
        wait_pulse(20, k, v);
        check("R8 divider restart", k, 8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule